// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Controller

This block models two chained eight-input priority interrupt controllers, a master and a slave. It covers the part of their work that runs while an interrupt is being acknowledged. Each controller keeps a pending-request register, an in-service register and a mask.

The slave's request output feeds master input 2. The master raises `int_out` when its best unmasked request outranks everything it has in service. The processor side then gives two low pulses on `ack_n`:

- **First pulse.** The winning request moves from pending to in-service. When the first pulse ends, the master places the index it granted on the three-bit `cas_id` bus.
- **Second pulse.** The vector byte appears. If `cas_id` names the slave, the slave supplies the vector. Otherwise the master supplies it.

Software or a mode input decides how in-service bits are cleared. Automatic clearing happens at the end of the second pulse. The alternative is a non-specific end-of-interrupt strobe, with one strobe for each controller.

Vector bases, masks and the automatic mode are ready-made inputs. Decoding of the initialization words lies outside the block. `ack_n` is sampled on `clk`, and every pulse low and every gap high must last at least one clock.

Top module: `cascade_ack_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `int_out`, `vec_valid` and `cas_id` read 0 and `vec` reads 8'h00.
- R2: A pending bit is set only by a 0-to-1 change of its input line. The bit is dropped when the line goes low before acknowledge. A line that stays high after service raises no new request.
- R3: Priority is fixed, with input 0 first and input 7 last. A vector granted by the master is `{base_m, index}`, with the index in bits [2:0] and the base in bits [7:3].
- R4: A masked input never raises `int_out` and never wins a grant. A request latched while masked becomes visible as soon as the mask bit clears.
- R5: `vec_valid` is high only during the second low pulse of an acknowledge. It is low during the first pulse and during the gap between the pulses.
- R6: The first pulse sets the in-service bit of the granted input and clears its pending bit. While that bit stays set, requests of equal or lower priority keep `int_out` low.
- R7: After the first pulse ends, `cas_id` holds the index the master granted, or 7 if nothing was granted. When `cas_id` equals 2, the slave supplies `{base_s, slave index}`.
- R8: Slave requests reach the master only through master input 2. Master inputs 0 and 1 outrank any slave request.
- R9: If the master has no unmasked pending request at the first pulse, the vector is `{base_m, 3'b111}` and no in-service bit is set.
- R10: With `aeoi_en` high, the granted in-service bit clears when the second pulse ends, with no end-of-interrupt strobe.
- R11: A one-cycle `eoi_m` or `eoi_s` clears only the highest-priority set in-service bit of that controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_m | input | 8 | Master request lines (bit 2 is OR-ed with the slave request) |
| irq_s | input | 8 | Slave request lines |
| mask_m | input | 8 | Master mask, 1 = input blocked |
| mask_s | input | 8 | Slave mask, 1 = input blocked |
| base_m | input | 5 | Master vector bits [7:3] |
| base_s | input | 5 | Slave vector bits [7:3] |
| aeoi_en | input | 1 | Automatic end-of-interrupt enable |
| ack_n | input | 1 | Acknowledge strobe, active low, two pulses per interrupt |
| eoi_m | input | 1 | Non-specific end-of-interrupt strobe for the master |
| eoi_s | input | 1 | Non-specific end-of-interrupt strobe for the slave |
| int_out | output | 1 | Interrupt request toward the processor |
| cas_id | output | 3 | Cascade identifier driven by the master after the first pulse |
| vec_valid | output | 1 | Vector byte is being driven |
| vec | output | 8 | Interrupt vector byte |

## Verification
The bench builds the block with its default parameters: the cascade on master input 2, slave identity 2 and spurious index 7. These values let one stimulus reach both a master grant and a routed slave grant, and let a withdrawn request produce the spurious vector. The spurious case is checked against a genuine input-7 request, so an in-service bit set by mistake would block it.

Nested in-service states are also built up. They show that end-of-interrupt removes only the highest-priority bit, and that automatic clearing frees lower-priority inputs without any strobe.

// File: rtl/cack_pkg.sv
package cack_pkg;

    localparam int N_IN     = 8;
    localparam int IDX_W    = $clog2(N_IN);
    localparam int BASE_W   = 8 - IDX_W;
    localparam int SPUR_IDX = N_IN - 1;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } sel_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_GAP    = 2'd2,
        PH_SECOND = 2'd3
    } phase_e;

    // lowest set index wins
    function automatic sel_t prio_pick(input logic [N_IN-1:0] v);
        sel_t r;
        r.valid = |v;
        r.idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (v[i]) r.idx = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] sel_idx(input sel_t s);
        return s.valid ? s.idx : IDX_W'(SPUR_IDX);
    endfunction

endpackage

// File: rtl/cack_unit.sv
module cack_unit
    import cack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  irq,
    input  logic [N_IN-1:0]  mask,
    input  logic             take,
    input  logic             clr,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             eoi,
    output logic             int_req,
    output sel_t             pick
);

    logic [N_IN-1:0] irq_q, irr, isr, irr_d, isr_d;
    sel_t            top_isr;

    always_comb begin
        pick    = prio_pick(irr & ~mask);
        top_isr = prio_pick(isr);
        int_req = pick.valid && (!top_isr.valid || (pick.idx < top_isr.idx));
    end

    always_comb begin
        irr_d = (irr | (irq & ~irq_q)) & irq;
        isr_d = isr;
        if (eoi && top_isr.valid) isr_d[top_isr.idx] = 1'b0;
        if (clr) isr_d[clr_idx] = 1'b0;
        if (take && pick.valid) begin
            irr_d[pick.idx] = 1'b0;
            isr_d[pick.idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        irq_q <= irq;
        if (rst) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= irr_d;
            isr <= isr_d;
        end
    end

    p_grant_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (take && pick.valid) |=> (isr[$past(pick.idx)] && !irr[$past(pick.idx)]));

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((irr & ~mask) != '0));

    p_auto_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !take) |=> !isr[$past(clr_idx)]);

    p_eoi_one_bit_r11: assert property (@(posedge clk) disable iff (rst)
        (eoi && !take && !clr && (isr != '0)) |=> ($countones($past(isr) ^ isr) == 1));

endmodule

// File: rtl/cack_seq.sv
module cack_seq
    import cack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ack_n,
    output logic   first_fall,
    output logic   first_rise,
    output logic   second_rise,
    output logic   in_second
);

    logic   ack_q;
    phase_e phase, phase_d;
    logic   fall, rise;

    always_comb begin
        fall        = ack_q && !ack_n;
        rise        = !ack_q && ack_n;
        first_fall  = (phase == PH_IDLE)   && fall;
        first_rise  = (phase == PH_FIRST)  && rise;
        second_rise = (phase == PH_SECOND) && rise;
        in_second   = (phase == PH_SECOND);
        phase_d     = phase;
        unique case (phase)
            PH_IDLE:   if (fall) phase_d = PH_FIRST;
            PH_FIRST:  if (rise) phase_d = PH_GAP;
            PH_GAP:    if (fall) phase_d = PH_SECOND;
            PH_SECOND: if (rise) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b1;
            phase <= PH_IDLE;
        end else begin
            ack_q <= ack_n;
            phase <= phase_d;
        end
    end

    p_second_after_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND) |-> ($past(phase) == PH_GAP || $past(phase) == PH_SECOND));

endmodule

// File: rtl/cascade_ack_ctrl.sv
module cascade_ack_ctrl
    import cack_pkg::*;
#(
    parameter int CASC_IN  = 2,
    parameter int SLAVE_ID = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   irq_m,
    input  logic [N_IN-1:0]   irq_s,
    input  logic [N_IN-1:0]   mask_m,
    input  logic [N_IN-1:0]   mask_s,
    input  logic [BASE_W-1:0] base_m,
    input  logic [BASE_W-1:0] base_s,
    input  logic              aeoi_en,
    input  logic              ack_n,
    input  logic              eoi_m,
    input  logic              eoi_s,
    output logic              int_out,
    output logic [IDX_W-1:0]  cas_id,
    output logic              vec_valid,
    output logic [7:0]        vec
);

    localparam logic [N_IN-1:0] CASC_BIT = N_IN'(1) << CASC_IN;

    logic            first_fall, first_rise, second_rise, in_second;
    logic            s_int, s_take, hit_slave, done_m, done_s;
    logic [N_IN-1:0] m_lines;
    sel_t            m_pick, s_pick, m_sel_q, s_sel_q;
    logic [IDX_W-1:0] cas_q;

    cack_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .ack_n       (ack_n),
        .first_fall  (first_fall),
        .first_rise  (first_rise),
        .second_rise (second_rise),
        .in_second   (in_second)
    );

    always_comb begin
        m_lines   = irq_m | (s_int ? CASC_BIT : '0);
        s_take    = first_fall && m_pick.valid && (m_pick.idx == IDX_W'(CASC_IN));
        hit_slave = m_sel_q.valid && (cas_q == IDX_W'(SLAVE_ID));
        done_m    = second_rise && aeoi_en && m_sel_q.valid;
        done_s    = done_m && hit_slave && s_sel_q.valid;
    end

    cack_unit u_master (
        .clk     (clk),
        .rst     (rst),
        .irq     (m_lines),
        .mask    (mask_m),
        .take    (first_fall),
        .clr     (done_m),
        .clr_idx (m_sel_q.idx),
        .eoi     (eoi_m),
        .int_req (int_out),
        .pick    (m_pick)
    );

    cack_unit u_slave (
        .clk     (clk),
        .rst     (rst),
        .irq     (irq_s),
        .mask    (mask_s),
        .take    (s_take),
        .clr     (done_s),
        .clr_idx (s_sel_q.idx),
        .eoi     (eoi_s),
        .int_req (s_int),
        .pick    (s_pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m_sel_q <= '0;
            s_sel_q <= '0;
            cas_q   <= '0;
        end else begin
            if (first_fall) begin
                m_sel_q <= m_pick;
                s_sel_q <= s_take ? s_pick : '0;
            end
            if (first_rise) cas_q <= sel_idx(m_sel_q);
        end
    end

    always_comb begin
        cas_id    = cas_q;
        vec_valid = in_second;
        vec       = '0;
        if (in_second) begin
            if (hit_slave) vec = {base_s, sel_idx(s_sel_q)};
            else           vec = {base_m, sel_idx(m_sel_q)};
        end
    end

    p_vec_in_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !$past(ack_n));

    p_spurious_code_r9: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !m_sel_q.valid) |-> (vec == {base_m, IDX_W'(SPUR_IDX)}));

    p_cas_held_r7: assert property (@(posedge clk) disable iff (rst)
        in_second |-> $stable(cas_id));

endmodule

// File: tb/cascade_ack_ctrl_tb.sv
module cascade_ack_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_m, irq_s, mask_m, mask_s;
    logic [4:0] base_m, base_s;
    logic       aeoi_en, ack_n, eoi_m, eoi_s;
    logic       int_out, vec_valid;
    logic [2:0] cas_id;
    logic [7:0] vec;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cascade_ack_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_m(irq_m), .irq_s(irq_s),
        .mask_m(mask_m), .mask_s(mask_s), .base_m(base_m), .base_s(base_s),
        .aeoi_en(aeoi_en), .ack_n(ack_n), .eoi_m(eoi_m), .eoi_s(eoi_s),
        .int_out(int_out), .cas_id(cas_id), .vec_valid(vec_valid), .vec(vec)
    );

    // {irq_m, irq_s, expected vec, expected cas_id}; base_m=0x08 (0x40), base_s=0x0E (0x70)
    localparam logic [26:0] TBL [0:5] = '{
        {8'h01, 8'h00, 8'h40, 3'd0},   // R3 input 0
        {8'h80, 8'h00, 8'h47, 3'd7},   // R3 input 7
        {8'h28, 8'h00, 8'h43, 3'd3},   // R3 3 beats 5
        {8'h00, 8'h10, 8'h74, 3'd2},   // R7 slave vector
        {8'h10, 8'h01, 8'h70, 3'd2},   // R8 cascade beats master 4
        {8'h02, 8'h01, 8'h41, 3'd1}    // R8 master 1 beats cascade
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_ack(output logic [7:0] v, output logic v1, output logic vg,
                          output logic [2:0] cs, output logic v2);
        ack_n = 1'b0; tick(2);
        v1 = vec_valid;
        ack_n = 1'b1; tick(2);
        vg = vec_valid; cs = cas_id;
        ack_n = 1'b0; tick(1);
        v = vec; v2 = vec_valid;
        tick(1);
        ack_n = 1'b1; tick(2);
    endtask

    task automatic pulse_eoi(input bit m, input bit s);
        eoi_m = m; eoi_s = s; tick(1);
        eoi_m = 1'b0; eoi_s = 1'b0; tick(1);
    endtask

    task automatic clear_all();
        irq_m = '0; irq_s = '0; tick(2);
        pulse_eoi(1, 1); pulse_eoi(1, 1); pulse_eoi(1, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       v1, vg, v2;
        logic [2:0] cs;

        rst = 1'b1; irq_m = '0; irq_s = '0; mask_m = '0; mask_s = '0;
        base_m = 5'h08; base_s = 5'h0E; aeoi_en = 1'b0; ack_n = 1'b1;
        eoi_m = 1'b0; eoi_s = 1'b0;
        tick(3);
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        rst = 1'b0; tick(1);
        check("R1 cas_id", {5'd0, cas_id}, 8'h00);
        check("R1 vec", vec, 8'h00);

        for (int i = 0; i < 6; i++) begin
            irq_m = TBL[i][26:19]; irq_s = TBL[i][18:11]; tick(3);
            check("R3 int_out raised", {7'd0, int_out}, 8'h01);
            do_ack(v, v1, vg, cs, v2);
            check("R5 valid first pulse", {7'd0, v1}, 8'h00);
            check("R5 valid gap", {7'd0, vg}, 8'h00);
            check("R5 valid second pulse", {7'd0, v2}, 8'h01);
            check("R7 cas_id", {5'd0, cs}, {5'd0, TBL[i][2:0]});
            check("R3 R7 R8 vector", v, TBL[i][10:3]);
            clear_all();
        end

        // R2: held line does not re-request; drop and raise does
        irq_m = 8'h20; tick(3);
        do_ack(v, v1, vg, cs, v2);
        check("R2 vec first", v, 8'h45);
        pulse_eoi(1, 0); tick(2);
        check("R2 held line no request", {7'd0, int_out}, 8'h00);
        irq_m = 8'h00; tick(2); irq_m = 8'h20; tick(2);
        check("R2 new edge requests", {7'd0, int_out}, 8'h01);
        clear_all();

        // R2 R9: withdrawn request gives spurious vector, no in-service bit
        irq_m = 8'h10; tick(2);
        check("R2 request pending", {7'd0, int_out}, 8'h01);
        irq_m = 8'h00; tick(2);
        check("R2 request withdrawn", {7'd0, int_out}, 8'h00);
        do_ack(v, v1, vg, cs, v2);
        check("R9 spurious vector", v, 8'h47);
        check("R7 spurious cas_id", {5'd0, cs}, 8'h07);
        irq_m = 8'h80; tick(2);
        check("R9 no in-service set", {7'd0, int_out}, 8'h01);
        do_ack(v, v1, vg, cs, v2);
        check("R9 real input 7", v, 8'h47);
        clear_all();

        // R4: mask
        mask_m = 8'h01; irq_m = 8'h01; tick(3);
        check("R4 masked no int", {7'd0, int_out}, 8'h00);
        mask_m = 8'h00; tick(1);
        check("R4 unmask shows latched", {7'd0, int_out}, 8'h01);
        do_ack(v, v1, vg, cs, v2);
        check("R4 vector after unmask", v, 8'h40);
        clear_all();

        // R6 R11: in-service blocks lower, EOI unblocks
        irq_m = 8'h08; tick(3);
        do_ack(v, v1, vg, cs, v2);
        irq_m = 8'h48; tick(2);
        check("R6 lower blocked", {7'd0, int_out}, 8'h00);
        pulse_eoi(1, 0); tick(1);
        check("R11 eoi unblocks", {7'd0, int_out}, 8'h01);
        do_ack(v, v1, vg, cs, v2);
        check("R6 vector after eoi", v, 8'h46);
        clear_all();

        // R11: only highest in-service bit cleared
        irq_m = 8'h20; tick(3);
        do_ack(v, v1, vg, cs, v2);
        irq_m = 8'h22; tick(2);
        check("R6 higher preempts", {7'd0, int_out}, 8'h01);
        do_ack(v, v1, vg, cs, v2);
        check("R11 vector 1", v, 8'h41);
        irq_m = 8'h2A; tick(2);
        check("R6 input 3 blocked by 1", {7'd0, int_out}, 8'h00);
        pulse_eoi(1, 0); tick(1);
        check("R11 highest cleared", {7'd0, int_out}, 8'h01);
        do_ack(v, v1, vg, cs, v2);
        check("R11 vector 3", v, 8'h43);
        clear_all();

        // R10: automatic end-of-interrupt
        aeoi_en = 1'b1;
        irq_m = 8'h08; tick(3);
        do_ack(v, v1, vg, cs, v2);
        check("R10 vector", v, 8'h43);
        irq_m = 8'h48; tick(2);
        check("R10 cleared without eoi", {7'd0, int_out}, 8'h01);
        do_ack(v, v1, vg, cs, v2);
        irq_m = 8'h00; irq_s = 8'h08; tick(3);
        do_ack(v, v1, vg, cs, v2);
        check("R10 slave vector", v, 8'h73);
        irq_s = 8'h00; tick(2); irq_s = 8'h08; tick(3);
        check("R10 slave and master cleared", {7'd0, int_out}, 8'h01);
        aeoi_en = 1'b0;
        clear_all();

        // R11: slave eoi independent
        irq_s = 8'h04; tick(3);
        do_ack(v, v1, vg, cs, v2);
        check("R7 slave 2", v, 8'h72);
        pulse_eoi(1, 0);
        irq_s = 8'h00; tick(2); irq_s = 8'h04; tick(3);
        check("R11 slave still in service", {7'd0, int_out}, 8'h00);
        pulse_eoi(0, 1); tick(2);
        check("R11 slave eoi frees", {7'd0, int_out}, 8'h01);
        clear_all();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule